// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a translation table in memory. A request carries the virtual address, the table base and a translation-enable bit. With translation off, the address comes back unchanged and memory is not read. With translation on, the walker reads one first-level word. It then either finishes on a 1 MB section or follows a pointer to a 256-entry second-level table and reads one more word there.

The result is a one-cycle pulse. It carries the physical address, the bufferable and cacheable attributes, the 4-bit domain and the 2-bit access-permission code. For small and large pages, that code is the one that belongs to the accessed quarter of the page. An illegal descriptor type produces a fault instead, tagged with the level at which it was found. Memory reads go over a valid/ready read port with at most one read in flight. The walker never checks permissions against a mode and keeps no translation cache.

Top module: `xlat_walker`

## Requirements
- R1: With `reqEnable` low, the result appears the cycle after acceptance. `rspPaddr` equals `reqVaddr`, no memory read is issued, `rspFault` is 0 and the attribute, domain and permission outputs are 0.
- R2: The first-level read address is {`reqBase`[31:14], `reqVaddr`[31:20], 2'b00}. Bits 13:0 of `reqBase` have no effect.
- R3: A first-level descriptor with bits 1:0 = 2'b10 ends the walk after one read. `rspPaddr` = {desc[31:20], va[19:0]}, the domain is desc[8:5] and the permission code is desc[11:10].
- R4: A first-level descriptor with bits 1:0 = 2'b01 causes a second read at {desc[31:10], va[19:12], 2'b00}. The domain reported is that first-level descriptor's bits 8:5.
- R5: A second-level descriptor with bits 1:0 = 2'b10 is a small page. `rspPaddr` = {desc[31:12], va[11:0]}. The permission code is desc[2k+5:2k+4], where k = va[11:10].
- R6: A second-level descriptor with bits 1:0 = 2'b01 is a large page. `rspPaddr` = {desc[31:16], va[15:0]}. The permission code is desc[2k+5:2k+4], where k = va[15:14].
- R7: `rspBufferable` is bit 2 and `rspCacheable` is bit 3 of the descriptor that ended the walk.
- R8: A first-level type of 2'b00 or 2'b11 gives `rspFault`=1 with `rspFaultLevel`=0 after exactly one read. `rspPaddr`, the attributes, the domain and the permission code are then all 0.
- R9: A second-level type of 2'b00 or 2'b11 gives `rspFault`=1 with `rspFaultLevel`=1 after two reads. The other result fields are 0.
- R10: Once raised, `memReqValid` stays high with a stable `memAddr` until `memReqReady`. No new read is raised while one is outstanding. `memRspReady` is high only while a response is awaited.
- R11: `reqReady` is high only while idle, never together with `rspValid` or `memReqValid`. `rspValid` is a single-cycle pulse, due one cycle after the final memory response (or after acceptance when translation is off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting |
| reqVaddr | input | 32 | Virtual address |
| reqBase | input | 32 | First-level table base (16 KB aligned) |
| reqEnable | input | 1 | Translation enable; low means pass-through |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memAddr | output | 32 | Word address of the descriptor read |
| memRspValid | input | 1 | Read data valid |
| memRspReady | output | 1 | Walker waiting for read data |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result pulse |
| rspPaddr | output | 32 | Physical address |
| rspBufferable | output | 1 | Bufferable attribute |
| rspCacheable | output | 1 | Cacheable attribute |
| rspDomain | output | 4 | Domain number |
| rspPerm | output | 2 | Permission code of the accessed sub-page |
| rspFault | output | 1 | Translation fault |
| rspFaultLevel | output | 1 | 0 = first level, 1 = second level |

## Verification
All result fields are registered and become visible together with `rspValid`, one clock after the descriptor that ends the walk is taken in. With translation off, that clock is the one after acceptance. A walk therefore takes two cycles plus the memory stall and latency per read. The bench waits for the `rspValid` pulse and samples every field on the falling edge of that cycle, then confirms the pulse has dropped one cycle later. A monitor checks at each rising edge that a result pulse follows directly after a final response or a pass-through acceptance. The number of accepted reads is compared per request, and a second pass repeats walks with a stalling read port.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W        = 32;
  localparam int L1_IDX_W    = 12;
  localparam int L2_IDX_W    = 8;
  localparam int SUBPAGES    = 4;
  localparam int AP_W        = 2;
  localparam int AP_LSB      = 4;
  localparam int DOM_W       = 4;
  localparam int DOM_LSB     = 5;
  localparam int BUF_BIT     = 2;
  localparam int CACHE_BIT   = 3;
  localparam int WORD_LSB    = 2;
  localparam int LARGE_XTRA  = 4;

  localparam int SECT_OFF_W  = VA_W - L1_IDX_W;
  localparam int SMALL_OFF_W = SECT_OFF_W - L2_IDX_W;
  localparam int LARGE_OFF_W = SMALL_OFF_W + LARGE_XTRA;
  localparam int TTB_LSB     = L1_IDX_W + WORD_LSB;
  localparam int L2TB_LSB    = L2_IDX_W + WORD_LSB;
  localparam int SUB_SEL_W   = $clog2(SUBPAGES);

  localparam logic [1:0] TYPE_PTR   = 2'b01;
  localparam logic [1:0] TYPE_BLOCK = 2'b10;

  typedef struct packed {
    logic loadReq;
    logic passThru;
    logic loadSection;
    logic loadTable;
    logic loadSmall;
    logic loadLarge;
    logic setFault;
    logic faultLevel;
    logic selL2;
  } xlatStrobes_t;
endpackage

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  xlatStrobes_t          stb,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic [VA_W-1:0]       reqBase,
  input  logic [VA_W-1:0]       memRspData,
  output logic [VA_W-1:0]       memAddr,
  output logic [1:0]            descType,
  output logic [VA_W-1:0]       rspPaddr,
  output logic                  rspBufferable,
  output logic                  rspCacheable,
  output logic [DOM_W-1:0]      rspDomain,
  output logic [AP_W-1:0]       rspPerm,
  output logic                  rspFault,
  output logic                  rspFaultLevel
);
  logic [VA_W-1:0]          vaReg;
  logic [VA_W-TTB_LSB-1:0]  baseHi;
  logic [VA_W-L2TB_LSB-1:0] l2Base;
  logic [DOM_W-1:0]         l1Dom;
  logic [AP_W-1:0]          apField [SUBPAGES];
  logic [SUB_SEL_W-1:0]     smallSel, largeSel;

  for (genvar g = 0; g < SUBPAGES; g++) begin : g_ap
    assign apField[g] = memRspData[AP_LSB + g*AP_W +: AP_W];
  end

  assign smallSel = vaReg[SMALL_OFF_W-1 -: SUB_SEL_W];
  assign largeSel = vaReg[LARGE_OFF_W-1 -: SUB_SEL_W];
  assign descType = memRspData[1:0];

  always_comb begin
    if (stb.selL2)
      memAddr = {l2Base, vaReg[SECT_OFF_W-1 -: L2_IDX_W], {WORD_LSB{1'b0}}};
    else
      memAddr = {baseHi, vaReg[VA_W-1 -: L1_IDX_W], {WORD_LSB{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg         <= '0;
      baseHi        <= '0;
      l2Base        <= '0;
      l1Dom         <= '0;
      rspPaddr      <= '0;
      rspBufferable <= 1'b0;
      rspCacheable  <= 1'b0;
      rspDomain     <= '0;
      rspPerm       <= '0;
      rspFault      <= 1'b0;
      rspFaultLevel <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        vaReg         <= reqVaddr;
        baseHi        <= reqBase[VA_W-1:TTB_LSB];
        rspPaddr      <= stb.passThru ? reqVaddr : '0;
        rspBufferable <= 1'b0;
        rspCacheable  <= 1'b0;
        rspDomain     <= '0;
        rspPerm       <= '0;
        rspFault      <= 1'b0;
        rspFaultLevel <= 1'b0;
      end
      if (stb.loadSection) begin
        rspPaddr      <= {memRspData[VA_W-1:SECT_OFF_W], vaReg[SECT_OFF_W-1:0]};
        rspBufferable <= memRspData[BUF_BIT];
        rspCacheable  <= memRspData[CACHE_BIT];
        rspDomain     <= memRspData[DOM_LSB +: DOM_W];
        rspPerm       <= apField[SUBPAGES-1];
      end
      if (stb.loadTable) begin
        l2Base <= memRspData[VA_W-1:L2TB_LSB];
        l1Dom  <= memRspData[DOM_LSB +: DOM_W];
      end
      if (stb.loadSmall) begin
        rspPaddr      <= {memRspData[VA_W-1:SMALL_OFF_W], vaReg[SMALL_OFF_W-1:0]};
        rspBufferable <= memRspData[BUF_BIT];
        rspCacheable  <= memRspData[CACHE_BIT];
        rspDomain     <= l1Dom;
        rspPerm       <= apField[smallSel];
      end
      if (stb.loadLarge) begin
        rspPaddr      <= {memRspData[VA_W-1:LARGE_OFF_W], vaReg[LARGE_OFF_W-1:0]};
        rspBufferable <= memRspData[BUF_BIT];
        rspCacheable  <= memRspData[CACHE_BIT];
        rspDomain     <= l1Dom;
        rspPerm       <= apField[largeSel];
      end
      if (stb.setFault) begin
        rspPaddr      <= '0;
        rspBufferable <= 1'b0;
        rspCacheable  <= 1'b0;
        rspDomain     <= '0;
        rspPerm       <= '0;
        rspFault      <= 1'b1;
        rspFaultLevel <= stb.faultLevel;
      end
    end
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqEnable,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic [1:0]   descType,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         memRspReady,
  output logic         rspValid,
  output xlatStrobes_t stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1REQ, ST_L1WAIT, ST_L2REQ, ST_L2WAIT, ST_DONE
  } walkState_t;

  walkState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memRspReady = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadReq  = 1'b1;
          stb.passThru = !reqEnable;
          stateNxt     = reqEnable ? ST_L1REQ : ST_DONE;
        end
      end
      ST_L1REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = ST_L1WAIT;
      end
      ST_L1WAIT: begin
        memRspReady = 1'b1;
        if (memRspValid) begin
          if (descType == TYPE_BLOCK) begin
            stb.loadSection = 1'b1;
            stateNxt        = ST_DONE;
          end else if (descType == TYPE_PTR) begin
            stb.loadTable = 1'b1;
            stateNxt      = ST_L2REQ;
          end else begin
            stb.setFault = 1'b1;
            stateNxt     = ST_DONE;
          end
        end
      end
      ST_L2REQ: begin
        stb.selL2   = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = ST_L2WAIT;
      end
      ST_L2WAIT: begin
        stb.selL2   = 1'b1;
        memRspReady = 1'b1;
        if (memRspValid) begin
          stateNxt = ST_DONE;
          if (descType == TYPE_BLOCK)      stb.loadSmall = 1'b1;
          else if (descType == TYPE_PTR)   stb.loadLarge = 1'b1;
          else begin
            stb.setFault   = 1'b1;
            stb.faultLevel = 1'b1;
          end
        end
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [VA_W-1:0]   reqBase,
  input  logic              reqEnable,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [VA_W-1:0]   memAddr,
  input  logic              memRspValid,
  output logic              memRspReady,
  input  logic [VA_W-1:0]   memRspData,
  output logic              rspValid,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspBufferable,
  output logic              rspCacheable,
  output logic [DOM_W-1:0]  rspDomain,
  output logic [AP_W-1:0]   rspPerm,
  output logic              rspFault,
  output logic              rspFaultLevel
);
  xlatStrobes_t stb;
  logic [1:0]   descType;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .descType(descType),
    .reqReady(reqReady), .memReqValid(memReqValid), .memRspReady(memRspReady),
    .rspValid(rspValid), .stb(stb)
  );

  xlat_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr), .reqBase(reqBase),
    .memRspData(memRspData), .memAddr(memAddr), .descType(descType),
    .rspPaddr(rspPaddr), .rspBufferable(rspBufferable), .rspCacheable(rspCacheable),
    .rspDomain(rspDomain), .rspPerm(rspPerm), .rspFault(rspFault),
    .rspFaultLevel(rspFaultLevel)
  );
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqEnable,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr,
  input logic        memRspValid,
  input logic        memRspReady,
  input logic        rspValid,
  input logic [31:0] rspPaddr,
  input logic        rspBufferable,
  input logic        rspCacheable,
  input logic        rspFault
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && memRspReady));

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[1:0] == 2'b00);

  p_idle_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rspValid && !memReqValid);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_bypass_timing_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqEnable |=> rspValid && !rspFault);

  p_fault_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPaddr == 32'd0 && !rspBufferable && !rspCacheable);

  p_result_after_rsp_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid && memRspReady |=> !memRspReady);
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqEnable(reqEnable), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memAddr(memAddr), .memRspValid(memRspValid), .memRspReady(memRspReady),
  .rspValid(rspValid), .rspPaddr(rspPaddr), .rspBufferable(rspBufferable),
  .rspCacheable(rspCacheable), .rspFault(rspFault)
);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [31:0] reqBase = '0;
  logic        reqEnable = 1'b0;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memAddr;
  logic        memRspValid;
  logic        memRspReady;
  logic [31:0] memRspData;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspBufferable, rspCacheable;
  logic [3:0]  rspDomain;
  logic [1:0]  rspPerm;
  logic        rspFault, rspFaultLevel;

  always #2 clk = ~clk;

  xlat_walker uut (.*);

  typedef struct packed {
    logic [4:0]  rq;
    logic [31:0] va;
    logic [31:0] base;
    logic        en;
    logic [31:0] pa;
    logic        b;
    logic        c;
    logic [3:0]  dom;
    logic [1:0]  perm;
    logic        flt;
    logic        lvl;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 14;
  // rq names the requirement each row targets
  localparam vec_t VECS [NV] = '{
    '{5'd1, 32'hDEADBEEF, 32'h00004000, 1'b0, 32'hDEADBEEF, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 2'd0}, // R1
    '{5'd3, 32'h00123456, 32'h00004000, 1'b1, 32'h80023456, 1'b1, 1'b1, 4'd5, 2'd2, 1'b0, 1'b0, 2'd1}, // R3 R7
    '{5'd2, 32'h00123456, 32'h00007FFC, 1'b1, 32'h80023456, 1'b1, 1'b1, 4'd5, 2'd2, 1'b0, 1'b0, 2'd1}, // R2
    '{5'd2, 32'h001FFFFF, 32'h00010000, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 2'd1}, // R2 other base
    '{5'd5, 32'h00205C10, 32'h00004000, 1'b1, 32'h12345C10, 1'b1, 1'b0, 4'd3, 2'd3, 1'b0, 1'b0, 2'd2}, // R5 R4 R7
    '{5'd5, 32'h00205400, 32'h00004000, 1'b1, 32'h12345400, 1'b1, 1'b0, 4'd3, 2'd1, 1'b0, 1'b0, 2'd2}, // R5
    '{5'd5, 32'h00205000, 32'h00004000, 1'b1, 32'h12345000, 1'b1, 1'b0, 4'd3, 2'd0, 1'b0, 1'b0, 2'd2}, // R5
    '{5'd5, 32'h00205BFF, 32'h00004000, 1'b1, 32'h12345BFF, 1'b1, 1'b0, 4'd3, 2'd2, 1'b0, 1'b0, 2'd2}, // R5
    '{5'd6, 32'h00210ABC, 32'h00004000, 1'b1, 32'hABCD0ABC, 1'b0, 1'b1, 4'd3, 2'd3, 1'b0, 1'b0, 2'd2}, // R6
    '{5'd6, 32'h00214123, 32'h00004000, 1'b1, 32'hABCD4123, 1'b0, 1'b1, 4'd3, 2'd2, 1'b0, 1'b0, 2'd2}, // R6
    '{5'd9, 32'h00220000, 32'h00004000, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 2'd2}, // R9
    '{5'd9, 32'h00221000, 32'h00004000, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 2'd2}, // R9
    '{5'd8, 32'h00300000, 32'h00004000, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1}, // R8
    '{5'd8, 32'h00400000, 32'h00004000, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1}  // R8
  };

  int checks = 0, fails = 0, monChecks = 0, monFails = 0;
  int readCount = 0;
  int stallLen = 0;
  int stallCnt = 0;
  logic        pend = 1'b0;
  int          latCnt = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // memory model: accepts one read, answers after two cycles
  always @(posedge clk) begin
    if (!rstN) begin
      memReqReady <= 1'b1;
      memRspValid <= 1'b0;
      memRspData  <= '0;
      pend        <= 1'b0;
      stallCnt    <= 0;
    end else begin
      memRspValid <= 1'b0;
      if (memReqValid && memReqReady) begin
        if (pend) begin
          monFails <= monFails + 1;
          $display("FAIL R10 second read while pending: actual addr=%h expected none", memAddr);
        end
        pend        <= 1'b1;
        pendAddr    <= memAddr;
        latCnt      <= 1;
        readCount   <= readCount + 1;
        memReqReady <= (stallLen == 0);
        stallCnt    <= 0;
      end else if (memReqValid && !memReqReady) begin
        stallCnt <= stallCnt + 1;
        if (stallCnt + 1 >= stallLen) memReqReady <= 1'b1;
      end
      if (pend) begin
        if (latCnt == 0) begin
          memRspValid <= 1'b1;
          memRspData  <= lookup(pendAddr);
          pend        <= 1'b0;
        end else latCnt <= latCnt - 1;
      end
    end
  end

  // edge monitor for R10 and R11
  logic        prevStall = 1'b0, prevFinal = 1'b0;
  logic [31:0] prevAddr = '0;
  always @(posedge clk) begin
    if (rstN) begin
      monChecks <= monChecks + 1;
      if (prevStall && !(memReqValid && memAddr == prevAddr)) begin
        monFails <= monFails + 1;
        $display("FAIL R10 request dropped or changed: actual v=%b a=%h expected v=1 a=%h",
                 memReqValid, memAddr, prevAddr);
      end
      if (rspValid && !prevFinal) begin
        monFails <= monFails + 1;
        $display("FAIL R11 result pulse not due: actual rspValid=1 expected 0");
      end
      if (reqReady && (rspValid || memReqValid)) begin
        monFails <= monFails + 1;
        $display("FAIL R11 ready while busy: actual rv=%b mv=%b expected 0 0", rspValid, memReqValid);
      end
    end
    prevStall <= rstN && memReqValid && !memReqReady;
    prevAddr  <= memAddr;
    prevFinal <= rstN && ((memRspValid && memRspReady) || (reqValid && reqReady && !reqEnable));
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int startReads;
    int t;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = v.va; reqBase = v.base; reqEnable = v.en;
    startReads = readCount;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!rspValid && t < 300) begin @(negedge clk); t++; end
    $display("vector %0d for R%0d", idx, v.rq);
    chk($sformatf("R%0d v%0d valid", v.rq, idx), {31'd0, rspValid}, 32'd1);
    chk($sformatf("R%0d v%0d paddr", v.rq, idx), rspPaddr, v.pa);
    chk($sformatf("R7 v%0d bufferable", idx), {31'd0, rspBufferable}, {31'd0, v.b});
    chk($sformatf("R7 v%0d cacheable", idx), {31'd0, rspCacheable}, {31'd0, v.c});
    chk($sformatf("R%0d v%0d domain", v.rq, idx), {28'd0, rspDomain}, {28'd0, v.dom});
    chk($sformatf("R%0d v%0d perm", v.rq, idx), {30'd0, rspPerm}, {30'd0, v.perm});
    chk($sformatf("R%0d v%0d fault", v.rq, idx), {30'd0, rspFault, rspFaultLevel},
        {30'd0, v.flt, v.lvl});
    chk($sformatf("R%0d v%0d reads", v.rq, idx), readCount - startReads, {30'd0, v.reads});
    @(negedge clk);
    chk($sformatf("R11 v%0d pulse ends", idx), {31'd0, rspValid}, 32'd0);
  endtask

  initial begin
    mem[32'h00004004] = 32'h800008AE; // section, dom 5, AP 2, C B
    mem[32'h00004008] = 32'h00008061; // table at 0x8000, dom 3
    mem[32'h00004010] = 32'h00000003; // illegal L1 type
    mem[32'h00010004] = 32'hFFF00002; // section in second table
    mem[32'h00008014] = 32'h12345E46; // small page, APs 0,1,2,3, B
    mem[32'h00008040] = 32'hABCD01B9; // large page, APs 3,2,1,0, C
    mem[32'h00008050] = 32'hABCD01B9;
    mem[32'h00008084] = 32'h00000003; // illegal L2 type

    repeat (3) @(negedge clk);
    // reset state
    chk("R11 reset reqReady", {31'd0, reqReady}, 32'd1);
    chk("R11 reset rspValid", {31'd0, rspValid}, 32'd0);
    chk("R10 reset memReqValid", {31'd0, memReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 idle memRspReady", {31'd0, memRspReady}, 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // stalling read port: R10 hold behaviour, results unchanged
    stallLen = 3;
    runVec(VECS[4], 4);
    runVec(VECS[8], 8);
    runVec(VECS[1], 1);
    stallLen = 0;

    // back-to-back pass-through then walk, R1 with low base bits set
    runVec('{5'd1, 32'h00000000, 32'hFFFFFFFF, 1'b0, 32'h00000000, 1'b0, 1'b0,
             4'd0, 2'd0, 1'b0, 1'b0, 2'd0}, 99);
    runVec(VECS[11], 11);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks + monChecks, fails + monFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks + monChecks + 1, fails + monFails + 1);
    $finish;
  end
endmodule